// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a single-register watchdog. Software writes one 32-bit control word that holds two small codes and a few enables. The prescaler code sets how many clock cycles make one tick. The interval code sets how many ticks make one timeout. Together the two codes give a coarse ladder of timeouts, each roughly four times the one below it. Software keeps the system alive by writing the control word back with the kick bit set before the count runs out.

A fixed number of ticks before the count runs out, a warning flag is set. While interrupt enable is set, that flag drives the interrupt line. When the count runs out with reset enable set, the block issues a one-cycle system reset request and records it in a sticky flag. With reset enable clear, the count simply wraps. Both flags stay set until software writes 1 to them. Writing an all-zero word stops the count. The bus fabric and the reset controller sit outside this block.

Top module: `wdt_timer`

## Requirements
- R1: After reset, `rd_data` is 0, `irq_o` is 0 and `sys_rst_req_o` is 0.
- R2: Control word layout: bits 11:10 prescaler code, bit 7 run enable, bit 6 interrupt enable, bits 5:4 interval code, bit 3 warning flag, bit 2 reset flag, bit 1 reset enable, bit 0 kick. Bit 0 and every unlisted bit always read 0.
- R3: One tick is 1 cycle for prescaler code 00, and 2^PRE_SH1, 2^PRE_SH2 or 2^PRE_SH3 cycles for codes 01, 10 and 11. The timeout is 2^(IVL_BASE + 2*interval code) ticks, counted from the write edge that started the count.
- R4: The warning flag (bit 3) is set WARN_TICKS ticks before the timeout, whether or not interrupt enable is set.
- R5: `irq_o` is high exactly while bit 3 and bit 6 are both 1.
- R6: At timeout with reset enable set, `sys_rst_req_o` is high for exactly one cycle, bit 2 is set on the same edge, and the count wraps to zero.
- R7: At timeout with reset enable clear, `sys_rst_req_o` stays low, bit 2 keeps its value, and the count wraps.
- R8: A write with bit 0 = 1 restarts the count from zero.
- R9: A write that changes the prescaler code or the interval code while running restarts the count, even without a kick.
- R10: With run enable clear, the count is held at zero, so no flag is set and no reset is requested. Writing all zeros stops the count.
- R11: Bits 3 and 2 are cleared by writing 1 to them and are kept by writing 0. A set event on the same edge wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word written when `wr_en` is high |
| rd_data | output | 32 | Current control word and status flags |
| irq_o | output | 1 | Early-warning interrupt, level high |
| sys_rst_req_o | output | 1 | One-cycle system reset request at timeout |

## Verification
The assertions assume that writes arrive only as single-cycle strobes with defined data and that `rst_n` is held low for at least one clock edge. They also assume that every timeout spans more than one cycle, so two reset requests can never fall on back-to-back edges. The stimulus keeps to these assumptions. It drives each write for exactly one cycle, away from the clock edge, and it uses small prescaler and interval parameters. With those parameters every timeout stays well above the warning distance and well within the run length.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Field positions inside the control word; software depends on them.
  localparam int BIT_KICK  = 0;
  localparam int BIT_RSTEN = 1;
  localparam int BIT_RFLAG = 2;
  localparam int BIT_WFLAG = 3;
  localparam int IVL_LO    = 4;
  localparam int BIT_IRQEN = 6;
  localparam int BIT_RUN   = 7;
  localparam int PRE_LO    = 10;
  localparam int REG_W     = 32;

  typedef struct packed {
    logic [1:0] presc;
    logic       run;
    logic       irq_en;
    logic [1:0] ivl;
    logic       rst_en;
  } wdt_cfg_t;

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             warn_hit,
  input  logic             expire_rst,
  output wdt_cfg_t         cfg,
  output logic             wflag,
  output logic             rflag,
  output logic             restart,
  output logic [REG_W-1:0] rd_data
);

  wdt_cfg_t cfg_q, cfg_d, cfg_wr;
  logic     wflag_q, wflag_d;
  logic     rflag_q, rflag_d;
  logic     unused_wr_bits;

  // Decode of the incoming word
  always_comb begin
    cfg_wr.presc  = wr_data[PRE_LO+1:PRE_LO];
    cfg_wr.run    = wr_data[BIT_RUN];
    cfg_wr.irq_en = wr_data[BIT_IRQEN];
    cfg_wr.ivl    = wr_data[IVL_LO+1:IVL_LO];
    cfg_wr.rst_en = wr_data[BIT_RSTEN];
  end

  assign unused_wr_bits = ^{wr_data[REG_W-1:PRE_LO+2], wr_data[PRE_LO-1:BIT_RUN+1]};

  // Next state
  always_comb begin
    cfg_d   = cfg_q;
    restart = 1'b0;
    if (wr_en) begin
      cfg_d   = cfg_wr;
      restart = wr_data[BIT_KICK]
              | (cfg_wr.presc != cfg_q.presc)
              | (cfg_wr.ivl   != cfg_q.ivl)
              | (cfg_wr.run   != cfg_q.run);
    end
    wflag_d = warn_hit   | (wflag_q & ~(wr_en & wr_data[BIT_WFLAG]));
    rflag_d = expire_rst | (rflag_q & ~(wr_en & wr_data[BIT_RFLAG]));
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      wflag_q <= 1'b0;
      rflag_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      wflag_q <= wflag_d;
      rflag_q <= rflag_d;
    end
  end

  // Read-back word; the kick bit is never stored
  always_comb begin
    rd_data                    = '0;
    rd_data[PRE_LO+1:PRE_LO]   = cfg_q.presc;
    rd_data[BIT_RUN]           = cfg_q.run;
    rd_data[BIT_IRQEN]         = cfg_q.irq_en;
    rd_data[IVL_LO+1:IVL_LO]   = cfg_q.ivl;
    rd_data[BIT_WFLAG]         = wflag_q;
    rd_data[BIT_RFLAG]         = rflag_q;
    rd_data[BIT_RSTEN]         = cfg_q.rst_en;
  end

  assign cfg   = cfg_q;
  assign wflag = wflag_q;
  assign rflag = rflag_q;

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_SH1 = 8,
  parameter int PRE_SH2 = 11,
  parameter int PRE_SH3 = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);

  localparam int PW = PRE_SH3;
  localparam logic [PW-1:0] LIM1 = PW'((32'd1 << PRE_SH1) - 32'd1);
  localparam logic [PW-1:0] LIM2 = PW'((32'd1 << PRE_SH2) - 32'd1);
  localparam logic [PW-1:0] LIM3 = PW'((32'd1 << PRE_SH3) - 32'd1);

  logic [PW-1:0] div_q, div_d, lim;

  always_comb begin
    unique case (sel)
      2'b00:   lim = '0;
      2'b01:   lim = LIM1;
      2'b10:   lim = LIM2;
      default: lim = LIM3;
    endcase
  end

  assign tick = run & (div_q == lim);

  always_comb begin
    if (restart || !run || tick) div_d = '0;
    else                         div_d = div_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int IVL_BASE   = 14,
  parameter int WARN_TICKS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic       tick,
  input  logic [1:0] ivl,
  output logic       warn_hit,
  output logic       expire
);

  localparam int CW = IVL_BASE + 6;

  logic [CW:0]   tc_w;
  logic [CW-1:0] last_w, warn_w;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          step;

  always_comb begin
    tc_w   = (CW+1)'(1) << (IVL_BASE + 2 * int'(ivl));
    last_w = CW'(tc_w - (CW+1)'(1));
    warn_w = CW'(tc_w - (CW+1)'(WARN_TICKS + 1));
  end

  assign step     = run & tick & ~restart;
  assign expire   = step & (cnt_q == last_w);
  assign warn_hit = step & (cnt_q == warn_w);

  always_comb begin
    if (restart || !run) cnt_d = '0;
    else if (step)       cnt_d = expire ? '0 : cnt_q + CW'(1);
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int PRE_SH1    = 8,
  parameter int PRE_SH2    = 11,
  parameter int PRE_SH3    = 16,
  parameter int IVL_BASE   = 14,
  parameter int WARN_TICKS = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_o,
  output logic             sys_rst_req_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  wdt_cfg_t   cfg;
  logic       wflag, rflag, restart, tick, warn_hit, expire, expire_rst;
  logic       req_q, req_d;

  // Reset synchronizer: asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wdt_ctrl_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .warn_hit   (warn_hit),
    .expire_rst (expire_rst),
    .cfg        (cfg),
    .wflag      (wflag),
    .rflag      (rflag),
    .restart    (restart),
    .rd_data    (rd_data)
  );

  wdt_prescaler #(
    .PRE_SH1 (PRE_SH1),
    .PRE_SH2 (PRE_SH2),
    .PRE_SH3 (PRE_SH3)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (cfg.run),
    .restart (restart),
    .sel     (cfg.presc),
    .tick    (tick)
  );

  wdt_counter #(
    .IVL_BASE   (IVL_BASE),
    .WARN_TICKS (WARN_TICKS)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (cfg.run),
    .restart  (restart),
    .tick     (tick),
    .ivl      (cfg.ivl),
    .warn_hit (warn_hit),
    .expire   (expire)
  );

  assign expire_rst = expire & cfg.rst_en;
  assign req_d      = expire_rst;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) req_q <= 1'b0;
    else            req_q <= req_d;
  end

  assign sys_rst_req_o = req_q;
  assign irq_o         = wflag & cfg.irq_en;

  logic unused_rflag;
  assign unused_rflag = rflag;

endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic wr_wclr,
  input logic wr_rclr,
  input logic run_bit,
  input logic ie_bit,
  input logic wf_bit,
  input logic rf_bit,
  input logic re_bit,
  input logic irq,
  input logic req
);

  p_req_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);

  p_req_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> rf_bit);

  p_req_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $past(re_bit));

  p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (wf_bit && ie_bit));

  p_stopped_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run_bit) |-> !req);

  p_wflag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wf_bit) && !($past(wr_en) && $past(wr_wclr))) |-> wf_bit);

  p_rflag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rf_bit) && !($past(wr_en) && $past(wr_rclr))) |-> rf_bit);

endmodule

bind wdt_timer wdt_timer_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_wclr (wr_data[3]),
  .wr_rclr (wr_data[2]),
  .run_bit (rd_data[7]),
  .ie_bit  (rd_data[6]),
  .wf_bit  (rd_data[3]),
  .rf_bit  (rd_data[2]),
  .re_bit  (rd_data[1]),
  .irq     (irq_o),
  .req     (sys_rst_req_o)
);

// File: tb/tb_wdt_timer.sv
module tb_wdt_timer;

  localparam int SH1 = 1, SH2 = 2, SH3 = 3, BASE = 4, WARN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_o, sys_rst_req_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct {
    int          at;
    logic        irq;
    logic        req;
    logic [31:0] rd;
    string       tag;
  } exp_t;
  exp_t q[$];

  wdt_timer #(
    .PRE_SH1 (SH1), .PRE_SH2 (SH2), .PRE_SH3 (SH3),
    .IVL_BASE (BASE), .WARN_TICKS (WARN)
  ) dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
    .rd_data (rd_data), .irq_o (irq_o), .sys_rst_req_o (sys_rst_req_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Model of the requirements
  function automatic int divider(input int p);
    case (p)
      0: return 1;
      1: return 1 << SH1;
      2: return 1 << SH2;
      default: return 1 << SH3;
    endcase
  endfunction

  function automatic int tmo_cyc(input int p, input int i);
    return divider(p) * (1 << (BASE + 2 * i));
  endfunction

  function automatic int warn_cyc(input int p, input int i);
    return divider(p) * ((1 << (BASE + 2 * i)) - WARN);
  endfunction

  function automatic logic [31:0] word(input int p, input bit run, input bit ie,
                                       input int i, input bit wf, input bit rf,
                                       input bit re);
    logic [31:0] w;
    w = '0;
    w[11:10] = 2'(p);
    w[7] = run; w[6] = ie;
    w[5:4] = 2'(i);
    w[3] = wf; w[2] = rf; w[1] = re;
    return w;
  endfunction

  task automatic expect_at(input int at, input logic irq, input logic req,
                           input logic [31:0] rd, input string tag);
    exp_t e;
    e.at = at; e.irq = irq; e.req = req; e.rd = rd; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic write_reg(input logic [31:0] d, output int edge_no);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    edge_no = cyc;
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
    #1;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    #1;
  endtask

  // Monitor: compares scoreboard items in the cycle they are due
  always @(negedge clk) begin
    while (q.size() != 0 && q[0].at <= cyc) begin
      checks++;
      if (q[0].at < cyc) begin
        errors++;
        $display("FAIL %s missed cycle %0d actual=late expected=on time", q[0].tag, q[0].at);
      end else if (irq_o !== q[0].irq || sys_rst_req_o !== q[0].req || rd_data !== q[0].rd) begin
        errors++;
        $display("FAIL %s cyc %0d actual irq=%0b req=%0b rd=%h expected irq=%0b req=%0b rd=%h",
                 q[0].tag, cyc, irq_o, sys_rst_req_o, rd_data, q[0].irq, q[0].req, q[0].rd);
      end
      void'(q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w, k, x;
    logic [31:0] c;

    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rd_data !== 32'h0 || irq_o !== 1'b0 || sys_rst_req_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual rd=%h irq=%0b req=%0b expected rd=0 irq=0 req=0",
               rd_data, irq_o, sys_rst_req_o);
    end
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Scenario A: divide-by-1, shortest interval, all enables, kick bit
    c = word(0, 1, 1, 0, 0, 0, 1);
    write_reg(c | 32'h1, w);
    expect_at(w, 0, 0, c, "R2 readback kick reads 0");
    expect_at(w + warn_cyc(0, 0) - 1, 0, 0, c, "R4 before warning");
    expect_at(w + warn_cyc(0, 0), 1, 0, c | 32'h8, "R4 R5 warning raises irq");
    expect_at(w + tmo_cyc(0, 0) - 1, 1, 0, c | 32'h8, "R3 before timeout");
    expect_at(w + tmo_cyc(0, 0), 1, 1, c | 32'hC, "R3 R6 reset request");
    expect_at(w + tmo_cyc(0, 0) + 1, 1, 0, c | 32'hC, "R6 one-cycle request");
    drain();
    write_reg(32'h0, x);
    expect_at(x, 0, 0, 32'hC, "R10 zero write stops, flags kept R11");
    expect_at(x + 40, 0, 0, 32'hC, "R10 stopped stays quiet");
    drain();
    write_reg(32'hC, x);
    expect_at(x, 0, 0, 32'h0, "R11 write one clears flags");
    drain();

    // Scenario B: prescaler 01, interval 01, reset disabled
    c = word(1, 1, 1, 1, 0, 0, 0);
    write_reg(c | 32'h1, w);
    expect_at(w, 0, 0, c, "R2 readback fields");
    expect_at(w + warn_cyc(1, 1) - 1, 0, 0, c, "R3 R4 before warning");
    expect_at(w + warn_cyc(1, 1), 1, 0, c | 32'h8, "R4 warning at scaled tick");
    expect_at(w + tmo_cyc(1, 1), 1, 0, c | 32'h8, "R7 no request without enable");
    expect_at(w + tmo_cyc(1, 1) + 1, 1, 0, c | 32'h8, "R7 reset flag untouched");
    drain();
    write_reg(32'hC, x);
    drain();

    // Scenario C: kick restarts the count, interrupt masked
    c = word(0, 1, 0, 0, 0, 0, 1);
    write_reg(c | 32'h1, w);
    expect_at(w + 5, 0, 0, c, "R8 running before kick");
    drain();
    wait_cyc(w + 9);
    write_reg(c | 32'h1, k);
    expect_at(k, 0, 0, c, "R8 kick accepted");
    expect_at(k + warn_cyc(0, 0) - 1, 0, 0, c, "R8 count restarted by kick");
    expect_at(k + warn_cyc(0, 0), 0, 0, c | 32'h8, "R5 flag set but irq masked");
    expect_at(k + tmo_cyc(0, 0), 0, 1, c | 32'hC, "R6 request after kick");
    drain();
    write_reg(32'hC, x);
    drain();

    // Scenario D: interval change restarts without kick; clear-on-one
    c = word(0, 1, 0, 0, 0, 0, 0);
    write_reg(c | 32'h1, w);
    expect_at(w + 5, 0, 0, c, "R9 running short interval");
    drain();
    wait_cyc(w + 6);
    c = word(0, 1, 0, 1, 0, 0, 0);
    write_reg(c, k);
    expect_at(k + warn_cyc(0, 1) - 1, 0, 0, c, "R9 field change restarts count");
    expect_at(k + warn_cyc(0, 1), 0, 0, c | 32'h8, "R9 warning from new interval");
    drain();
    write_reg(c | 32'h8, x);
    expect_at(x, 0, 0, c, "R11 warning flag cleared, no restart");
    expect_at(k + tmo_cyc(0, 1) + 1, 0, 0, c, "R7 wrap keeps reset flag clear");
    drain();
    write_reg(32'hC, x);
    drain();

    // Scenario E: slowest prescaler
    c = word(3, 1, 0, 0, 0, 0, 1);
    write_reg(c | 32'h1, w);
    expect_at(w, 0, 0, c, "R2 prescaler field readback");
    expect_at(w + warn_cyc(3, 0) - 1, 0, 0, c, "R3 before warning prescaled");
    expect_at(w + warn_cyc(3, 0), 0, 0, c | 32'h8, "R4 prescaled warning");
    expect_at(w + tmo_cyc(3, 0) - 1, 0, 0, c | 32'h8, "R3 before prescaled timeout");
    expect_at(w + tmo_cyc(3, 0), 0, 1, c | 32'hC, "R3 R6 prescaled timeout");
    drain();
    write_reg(32'hC, x);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule